// File: doc/BRIEF.md
# Word-at-a-time Packet Transmit Bridge

This block sits on a small embedded processor's memory-mapped bus and turns packets that software assembles one bus word at a time into a stream of beats toward a 10G network port. Software first writes the packet's byte length. Then, for each word, it writes a descriptor word holding the byte strobe, the end-of-packet flag and the one-hot source and destination port bytes, followed by the data word itself. Only the data write produces a stream beat. Each beat takes its keep, tuser and tlast from whatever descriptor is currently latched, so a descriptor stays in force across any number of data writes until software replaces it.

A small beat FIFO lets the bus side run ahead of the stream side. A status word reports how many beats the FIFO can still take, so software can pace itself. If a data word arrives while the FIFO is full, the word is discarded and a sticky overflow flag is raised. Data words are big-endian: the first packet byte is in the most significant lane. The descriptor's low-order strobe run is therefore mirrored onto the keep bits so that keep marks lanes from the top down.

A two-state packet tracker records whether a packet is being assembled. A length write moves it from IDLE to OPEN, and the length appears on a side output. A data write whose latched descriptor carries the end flag returns it from OPEN to IDLE. A length write while OPEN restarts the packet and stays in OPEN.

Top module: `pio_tx_bridge`

## Requirements
- R1: After reset `m_tvalid` is 0, `pkt_open_o` is 0, the descriptor register reads 0 and the status word at 0x18 reads free count = DEPTH with the overflow bit clear.
- R2: Registers decode at byte offsets 0x00 (data, write), 0x08 (descriptor, read/write, 32 bits) and 0x10 (length, bits 15:0, read/write). Reading 0x00 or any other offset returns 0.
- R3: Each accepted data write yields exactly one stream beat. Descriptor, length and status writes yield none.
- R4: `m_tdata` equals the written data word unchanged. `m_tkeep[NB-1-i]` equals descriptor bit i for each strobe bit i in bits NB-1:0, so a strobe of 0x3 gives keep 4'b1100 on a 32-bit path.
- R5: `m_tuser` equals descriptor bits 31:16: destination port byte in bits 15:8 and source port byte in bits 7:0. `m_tlast` equals descriptor bit 15.
- R6: The latched descriptor applies to every later data write until the descriptor is written again.
- R7: Beats leave in write order. While `m_tvalid` is high and `m_tready` is low, the beat on the output is held unchanged.
- R8: A data write while the FIFO holds DEPTH beats is dropped and sets the sticky overflow flag (status bit 31). Writing 0x18 with bit 31 set clears the flag; if an overflow occurs in the same cycle, the flag stays set.
- R9: Status bits 15:0 read DEPTH minus the number of beats held.
- R10: A length write moves the tracker to OPEN (`pkt_open_o`=1) and shows the length on `pkt_len_o` from the next cycle. A data write while OPEN with descriptor bit 15 set returns it to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| m_tdata | output | DATA_W | Stream data, first byte in the top lane |
| m_tkeep | output | DATA_W/8 | Stream byte enables, top lane first |
| m_tuser | output | 16 | {destination port, source port} |
| m_tlast | output | 1 | End of packet |
| m_tvalid | output | 1 | Beat available |
| m_tready | input | 1 | Sink accepts the beat |
| pkt_len_o | output | 16 | Length captured for the current packet |
| pkt_open_o | output | 1 | Tracker in OPEN state |

## Verification
On every cycle, the in-module properties check four things: the overflow flag stays set until it is cleared, a length write opens the tracker and captures the length, the descriptor holds when it is not written, and a stalled beat stays stable. They also check that the FIFO is never pushed when full and that the free count never exceeds DEPTH. Several behaviours are visible only through the bench's scenarios: the mirrored keep bits, the port bytes on tuser, descriptor reuse, the exact set of beats that survive an overflow, and ordering under random backpressure. The bench checks these by comparing every beat that leaves the block against a queue of beats predicted from the register writes.

// File: rtl/pio_tx_pkg.sv
`timescale 1ns/1ps
package pio_tx_pkg;

    typedef enum logic [0:0] {
        PKT_IDLE = 1'b0,
        PKT_OPEN = 1'b1
    } pkt_state_e;

    localparam int OFS_DATA  = 'h00;
    localparam int OFS_DESC  = 'h08;
    localparam int OFS_LEN   = 'h10;
    localparam int OFS_STAT  = 'h18;

    localparam int END_BIT   = 15;
    localparam int SRC_LO    = 16;
    localparam int PORT_W    = 8;
    localparam int OVF_BIT   = 31;
    localparam int LEN_W     = 16;
    localparam int USER_W    = 2 * PORT_W;

endpackage

// File: rtl/pio_tx_fifo.sv
`timescale 1ns/1ps
module pio_tx_fifo #(
    parameter int WIDTH = 53,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             valid_o,
    output logic             full_o,
    output logic [CNT_W-1:0] free_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && valid_o;
    assign valid_o = (cnt_q != '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign free_o  = CNT_W'(DEPTH) - cnt_q;
    assign dout_o  = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wptr_q <= (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            end
            if (do_pop) begin
                rptr_q <= (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R8: the register block must never push into a full FIFO
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R9: free space never exceeds the depth
    p_free_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        free_o <= CNT_W'(DEPTH));

endmodule

// File: rtl/pio_tx_regs.sv
`timescale 1ns/1ps
module pio_tx_regs
    import pio_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4,
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fifo_full_i,
    input  logic [CNT_W-1:0]  fifo_free_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              push_o,
    output logic [DATA_W-1:0] beat_data_o,
    output logic [NB-1:0]     beat_keep_o,
    output logic [USER_W-1:0] beat_user_o,
    output logic              beat_last_o,
    output logic [LEN_W-1:0]  pkt_len_o,
    output logic              pkt_open_o
);
    pkt_state_e       state_q, state_d;
    logic [31:0]      desc_q;
    logic [LEN_W-1:0] len_q;
    logic             ovf_q;
    logic             wr_data, wr_desc, wr_len, wr_stat, ovf_clr, drop;
    logic [31:0]      stat_word;

    // address decode
    assign wr_data = wr_i && (addr_i == ADDR_W'(OFS_DATA));
    assign wr_desc = wr_i && (addr_i == ADDR_W'(OFS_DESC));
    assign wr_len  = wr_i && (addr_i == ADDR_W'(OFS_LEN));
    assign wr_stat = wr_i && (addr_i == ADDR_W'(OFS_STAT));
    assign ovf_clr = wr_stat && wdata_i[OVF_BIT];
    assign drop    = wr_data && fifo_full_i;

    // beat formation from the latched descriptor
    assign push_o      = wr_data && !fifo_full_i;
    assign beat_data_o = wdata_i;
    assign beat_user_o = desc_q[SRC_LO +: USER_W];
    assign beat_last_o = desc_q[END_BIT];

    // strobe run counts from bit 0, lanes count from the top
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign beat_keep_o[NB-1-i] = desc_q[i];
    end

    // descriptor, length and overflow storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            len_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_desc) begin
                desc_q <= wdata_i[31:0];
            end
            if (wr_len) begin
                len_q <= wdata_i[LEN_W-1:0];
            end
            if (drop) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end

    // packet tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PKT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // packet tracker: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PKT_IDLE: begin
                if (wr_len) begin
                    state_d = PKT_OPEN;
                end
            end
            PKT_OPEN: begin
                if (wr_len) begin
                    state_d = PKT_OPEN;
                end else if (wr_data && desc_q[END_BIT]) begin
                    state_d = PKT_IDLE;
                end
            end
            default: state_d = PKT_IDLE;
        endcase
    end

    // packet tracker: outputs
    always_comb begin
        pkt_open_o = (state_q == PKT_OPEN);
        pkt_len_o  = len_q;
    end

    // read mux
    always_comb begin
        stat_word          = 32'(fifo_free_i);
        stat_word[OVF_BIT] = ovf_q;
        case (addr_i)
            ADDR_W'(OFS_DESC): rdata_o = DATA_W'(desc_q);
            ADDR_W'(OFS_LEN):  rdata_o = DATA_W'(len_q);
            ADDR_W'(OFS_STAT): rdata_o = DATA_W'(stat_word);
            default:           rdata_o = '0;
        endcase
    end

    // R8: overflow flag is sticky until a clearing write
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R10: a length write opens the packet and captures the length
    p_len_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_len |=> (pkt_open_o && pkt_len_o == $past(wdata_i[LEN_W-1:0])));

    // R6: the descriptor only changes on its own write
    p_desc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_desc |=> $stable(desc_q));

endmodule

// File: rtl/pio_tx_bridge.sv
`timescale 1ns/1ps
module pio_tx_bridge
    import pio_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    localparam int NB    = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int BEAT_W = DATA_W + NB + USER_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] m_tdata,
    output logic [NB-1:0]     m_tkeep,
    output logic [USER_W-1:0] m_tuser,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [LEN_W-1:0]  pkt_len_o,
    output logic              pkt_open_o
);
    logic              push, full;
    logic [CNT_W-1:0]  free;
    logic [DATA_W-1:0] b_data;
    logic [NB-1:0]     b_keep;
    logic [USER_W-1:0] b_user;
    logic              b_last;
    logic [BEAT_W-1:0] fifo_in, fifo_out;

    pio_tx_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .fifo_full_i (full),
        .fifo_free_i (free),
        .rdata_o     (bus_rdata),
        .push_o      (push),
        .beat_data_o (b_data),
        .beat_keep_o (b_keep),
        .beat_user_o (b_user),
        .beat_last_o (b_last),
        .pkt_len_o   (pkt_len_o),
        .pkt_open_o  (pkt_open_o)
    );

    assign fifo_in = {b_data, b_keep, b_user, b_last};

    pio_tx_fifo #(
        .WIDTH (BEAT_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (fifo_in),
        .pop_i   (m_tready),
        .dout_o  (fifo_out),
        .valid_o (m_tvalid),
        .full_o  (full),
        .free_o  (free)
    );

    assign {m_tdata, m_tkeep, m_tuser, m_tlast} = fifo_out;

    // R7: a stalled beat stays on the output unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
            $stable(m_tkeep) && $stable(m_tuser) && $stable(m_tlast)));

endmodule

// File: tb/sim_pio_tx_bridge.sv
`timescale 1ns/1ps
module sim_pio_tx_bridge;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] m_tdata;
    logic [NB-1:0] m_tkeep;
    logic [15:0]   m_tuser;
    logic          m_tlast, m_tvalid;
    logic          m_tready = 1'b0;
    logic [15:0]   pkt_len_o;
    logic          pkt_open_o;

    int n_chk = 0, n_bad = 0, n_sent = 0, n_rcv = 0;
    int ready_mode = 0;
    bit done = 1'b0;
    logic [63:0] exp_q[$];
    logic [63:0] prev_beat = '0;
    bit prev_stall = 1'b0;

    always #5 clk = ~clk;

    pio_tx_bridge #(.DATA_W(DW), .ADDR_W(8), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .m_tdata(m_tdata),
        .m_tkeep(m_tkeep), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .pkt_len_o(pkt_len_o),
        .pkt_open_o(pkt_open_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] mirror_keep(input logic [31:0] desc);
        logic [NB-1:0] k;
        for (int i = 0; i < NB; i++) k[NB-1-i] = desc[i];
        return k;
    endfunction

    function automatic logic [63:0] beat_of(input logic [31:0] desc, input logic [DW-1:0] d);
        return 64'({d, mirror_keep(desc), desc[31:16], desc[15]});
    endfunction

    function automatic logic [31:0] make_desc(input logic [7:0] dst, input logic [7:0] src,
                                              input bit last, input int nbytes);
        logic [31:0] s;
        s = (nbytes >= NB) ? 32'((1 << NB) - 1) : 32'((1 << nbytes) - 1);
        return {dst, src, last, 7'd0, 8'(s)};
    endfunction

    // stream sink: tready policy
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: m_tready = 1'b0;
            1: m_tready = 1'b1;
            default: m_tready = ($urandom % 3) != 0;
        endcase
    end

    // stream monitor: beats move at the next edge, sampled mid-cycle
    always @(negedge clk) begin
        logic [63:0] cur;
        cur = 64'({m_tdata, m_tkeep, m_tuser, m_tlast});
        if (rst_n && prev_stall) begin
            chk(m_tvalid && cur == prev_beat, "R7 stalled beat held", cur, prev_beat);
        end
        prev_stall = rst_n && m_tvalid && !m_tready;
        prev_beat  = cur;
        if (rst_n && m_tvalid && m_tready) begin
            n_rcv++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 beat with no data write", cur, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk(cur == e, "R4 R5 R7 beat content/order", cur, e);
            end
        end
    end

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [31:0] desc, input logic [31:0] d, input bit accepted);
        bwr(8'h00, d);
        if (accepted) begin
            exp_q.push_back(beat_of(desc, d));
            n_sent++;
        end
    endtask

    initial begin
        logic [31:0] v, desc;
        void'($urandom(32'd1913));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 reset state
        chk(!m_tvalid, "R1 tvalid after reset", 64'(m_tvalid), 64'd0);
        chk(!pkt_open_o, "R1 tracker idle after reset", 64'(pkt_open_o), 64'd0);
        brd(8'h18, v);
        chk(v == 32'(DEPTH), "R1 status after reset", 64'(v), 64'(DEPTH));
        brd(8'h08, v);
        chk(v == 0, "R1 descriptor after reset", 64'(v), 64'd0);

        // R10 / R2 length capture, R3 no beat from descriptor/length writes
        bwr(8'h10, 32'd6);
        chk(pkt_open_o, "R10 open after length write", 64'(pkt_open_o), 64'd1);
        chk(pkt_len_o == 16'd6, "R10 pkt_len_o", 64'(pkt_len_o), 64'd6);
        brd(8'h10, v);
        chk(v == 6, "R2 length readback", 64'(v), 64'd6);
        desc = make_desc(8'h04, 8'h02, 1'b0, 4);
        bwr(8'h08, desc);
        brd(8'h08, v);
        chk(v == desc, "R2 descriptor readback", 64'(v), 64'(desc));
        brd(8'h00, v);
        chk(v == 0, "R2 data offset reads zero", 64'(v), 64'd0);
        brd(8'h18, v);
        chk(v == 32'(DEPTH), "R3 no beat from desc/len writes", 64'(v), 64'(DEPTH));
        chk(!m_tvalid, "R3 tvalid stays low", 64'(m_tvalid), 64'd0);
        send(desc, 32'hA1A2_A3A4, 1'b1);
        chk(pkt_open_o, "R10 still open before end", 64'(pkt_open_o), 64'd1);
        desc = make_desc(8'h04, 8'h02, 1'b1, 2);
        bwr(8'h08, desc);
        send(desc, 32'hB1B2_0000, 1'b1);
        chk(!pkt_open_o, "R10 closed by end beat", 64'(pkt_open_o), 64'd0);
        chk(m_tkeep == 4'b1111, "R4 full keep on head beat", 64'(m_tkeep), 64'hF);
        brd(8'h18, v);
        chk(v == 32'(DEPTH - 2), "R9 free after two beats", 64'(v), 64'(DEPTH - 2));

        // R6 descriptor reuse, then fill to R8 overflow
        desc = make_desc(8'h01, 8'h02, 1'b0, 4);
        bwr(8'h08, desc);
        for (int i = 0; i < DEPTH - 2; i++) send(desc, 32'hC000_0000 + 32'(i), 1'b1);
        brd(8'h18, v);
        chk(v == 0, "R9 free at full", 64'(v), 64'd0);
        send(desc, 32'hDEAD_BEEF, 1'b0);
        brd(8'h18, v);
        chk(v == 32'h8000_0000, "R8 overflow flag set, word dropped", 64'(v), 64'h8000_0000);
        ready_mode = 1;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        brd(8'h18, v);
        chk(v == 32'h8000_0000 + 32'(DEPTH), "R8 flag sticky after drain", 64'(v), 64'h8000_0000 + 64'(DEPTH));
        bwr(8'h18, 32'h8000_0000);
        brd(8'h18, v);
        chk(v == 32'(DEPTH), "R8 flag cleared", 64'(v), 64'(DEPTH));
        chk(n_rcv == n_sent, "R8 only accepted beats emerged", 64'(n_rcv), 64'(n_sent));

        // random packets under random backpressure
        ready_mode = 2;
        for (int p = 0; p < 40; p++) begin
            int len, words;
            logic [7:0] dst;
            len   = 1 + int'($urandom % 20);
            words = (len + NB - 1) / NB;
            dst   = 8'(1 << (2 * ($urandom % 4)));
            bwr(8'h10, 32'(len));
            for (int w = 0; w < words; w++) begin
                bit last;
                last = (w == words - 1);
                desc = make_desc(dst, 8'h02, last, len - w * NB);
                bwr(8'h08, desc);
                brd(8'h18, v);
                while (v[15:0] == 0) brd(8'h18, v);
                send(desc, $urandom, 1'b1);
            end
            chk(!pkt_open_o, "R10 closed after random packet", 64'(pkt_open_o), 64'd0);
        end
        ready_mode = 1;
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        chk(n_rcv == n_sent, "R3 one beat per data write", 64'(n_rcv), 64'(n_sent));
        brd(8'h18, v);
        chk(v == 32'(DEPTH), "R9 free restored, no overflow", 64'(v), 64'(DEPTH));
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 actual=timeout expected=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule